// File: doc/BRIEF.md
# Path-Correlated Indirect Branch Target Predictor

This block improves target prediction for indirect branches whose destination changes with the control-flow path that led to them. It sits beside a base target array that is outside the block. On every fetch it takes the branch address, the global branch-direction history and the base array's lookup result: hit flag, branch kind and target. It forms a key by XORing the history into the branch address and looks that key up in a direct-mapped, partially tagged table. When the base array reports an indirect branch and the table hits, the table's target replaces the base target. In every other case the base target passes through unchanged.

Entries are created only after a misprediction. The resolve port carries the branch address, the history value that was used when the branch was fetched, the branch kind, the target this block predicted and the target actually taken. When an indirect branch resolves with a target different from the predicted one, the slot for that key is written with the actual target. The write either allocates a new entry or overwrites the stale target of an existing entry. A branch that always goes to one place never mispredicts, so it never takes a slot here. A branch whose target depends on the data takes one slot for each history context in which it was wrong.

The lookup is combinational from the fetch inputs. A resolve write lands on the next rising clock edge.

Top module: `itp_predictor`

## Requirements
- R1: While reset is asserted and after it is released, every entry is invalid, so `pred_tgt` equals `fb_tgt` for any fetch inputs until a write is made.
- R2: `pred_tgt` takes the stored target when three conditions all hold: `fb_hit` is 1, `fb_kind` is 2'b11 (indirect), and the entry at the fetch index is valid and its tag matches. The other kind codes are 2'b00 conditional, 2'b01 return and 2'b10 call.
- R3: When `fb_hit` is 0 or `fb_kind` is not 2'b11, `pred_tgt` equals `fb_tgt`, even if the table holds a matching entry.
- R4: The key is `ip[15:0] ^ ghr[15:0]`, with default parameters and no history folding. Index is key[7:0] and tag is key[15:8]. Address bits 31:16 do not take part, and two address/history pairs with the same XOR select the same entry.
- R5: A resolve with `rs_valid`=1, `rs_kind`=2'b11 and `rs_pred_tgt` != `rs_act_tgt` writes the entry at the resolve key as valid, with the resolve tag and `rs_act_tgt`.
- R6: A resolve whose predicted target equals its actual target changes no entry.
- R7: A resolve whose kind is not 2'b11 changes no entry, even when the targets differ.
- R8: One branch address with different history values holds independent targets in separate entries.
- R9: A fetch that selects a valid entry whose tag differs from the fetch tag is a miss, and `fb_tgt` is passed through.
- R10: A write to an index that holds a valid entry with another tag replaces that entry. The old key then misses.
- R11: A resolve that hits an entry with a wrong target overwrites the stored target with the actual one.
- R12: A write becomes visible to lookups from the cycle after its clock edge. A lookup in the same cycle as the write sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; invalidates all entries |
| fe_ip | input | 32 | Fetch branch address |
| fe_ghr | input | 16 | Global history at fetch |
| fb_hit | input | 1 | Base target array hit |
| fb_kind | input | 2 | Base target array branch kind (2'b11 indirect) |
| fb_tgt | input | 32 | Base target array target |
| pred_tgt | output | 32 | Final predicted target |
| rs_valid | input | 1 | Resolve record present this cycle |
| rs_ip | input | 32 | Resolved branch address |
| rs_ghr | input | 16 | History value used at fetch of the resolved branch |
| rs_kind | input | 2 | Resolved branch kind (2'b11 indirect) |
| rs_pred_tgt | input | 32 | Target that was predicted for the resolved branch |
| rs_act_tgt | input | 32 | Actual target of the resolved branch |

## Verification
A wrong valid bit, tag or target inside the table appears at `pred_tgt` only when a later fetch selects that key, marks the branch indirect and reports a base hit. In that case the port shows either the base target where a learned target was expected, or the reverse. The error is visible in the first such fetch after the faulty write, one clock edge later. Because of this, the directed cases revisit each written key with the base target set to a distinct value. They also probe neighbouring keys that share an index but differ in tag, so that a lost write, a stray write or a skipped tag compare changes the visible target.

// File: rtl/itp_pkg.sv
package itp_pkg;

   typedef enum logic [1:0] {
      BK_COND = 2'b00,
      BK_RET  = 2'b01,
      BK_CALL = 2'b10,
      BK_IND  = 2'b11
   } br_kind_e;

   localparam logic [1:0] KIND_INDIRECT = 2'b11;

endpackage

// File: rtl/itp_hash.sv
module itp_hash #(
   parameter int IP_W      = 32,
   parameter int HIST_W    = 16,
   parameter int IP_LSB    = 0,
   parameter int IDX_W     = 8,
   parameter int TAG_W     = 8,
   parameter bit FOLD_HIST = 1'b0
) (
   input  logic [IP_W-1:0]   ip,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag
);
   localparam int KEY_W = IDX_W + TAG_W;

   logic [KEY_W-1:0] ip_key;
   logic [KEY_W-1:0] hist_key;
   logic [KEY_W-1:0] key;

   if (IP_LSB + KEY_W > IP_W) begin : g_bad_width
      $error("itp_hash: address too narrow for key");
   end

   assign ip_key = ip[IP_LSB +: KEY_W];

   if (FOLD_HIST) begin : g_fold
      localparam int NCH = (HIST_W + KEY_W - 1) / KEY_W;
      logic [NCH*KEY_W-1:0] padded;
      always_comb begin
         padded = '0;
         padded[HIST_W-1:0] = hist;
         hist_key = '0;
         for (int c = 0; c < NCH; c++) begin
            hist_key = hist_key ^ padded[c*KEY_W +: KEY_W];
         end
      end
   end else begin : g_trunc
      if (HIST_W >= KEY_W) begin : g_cut
         assign hist_key = hist[KEY_W-1:0];
      end else begin : g_ext
         assign hist_key = {{(KEY_W-HIST_W){1'b0}}, hist};
      end
   end

   assign key = ip_key ^ hist_key;
   assign idx = key[IDX_W-1:0];
   assign tag = key[KEY_W-1:IDX_W];

endmodule

// File: rtl/itp_table.sv
module itp_table #(
   parameter int IDX_W = 8,
   parameter int TAG_W = 8,
   parameter int TGT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [TGT_W-1:0] rd_tgt,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [TGT_W-1:0] wr_tgt,
   output logic [(1<<IDX_W)-1:0] vld_o
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] vld_q;
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [TGT_W-1:0] tgt_q [DEPTH];

   if (IDX_W < 1 || TAG_W < 1 || TGT_W < 1) begin : g_bad_cfg
      $error("itp_table: widths must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_tgt;
      end
   end

   assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_tgt = tgt_q[rd_idx];
   assign vld_o  = vld_q;

endmodule

// File: rtl/itp_select.sv
module itp_select
   import itp_pkg::*;
#(
   parameter int TGT_W = 32
) (
   input  logic             base_hit,
   input  logic [1:0]       base_kind,
   input  logic [TGT_W-1:0] base_tgt,
   input  logic             tbl_hit,
   input  logic [TGT_W-1:0] tbl_tgt,
   output logic [TGT_W-1:0] out_tgt
);
   logic is_indirect;

   assign is_indirect = base_hit && (base_kind == KIND_INDIRECT);
   assign out_tgt     = (is_indirect && tbl_hit) ? tbl_tgt : base_tgt;

endmodule

// File: rtl/itp_update.sv
module itp_update
   import itp_pkg::*;
#(
   parameter int TGT_W = 32
) (
   input  logic             rs_valid,
   input  logic [1:0]       rs_kind,
   input  logic [TGT_W-1:0] rs_pred_tgt,
   input  logic [TGT_W-1:0] rs_act_tgt,
   output logic             wr_en
);
   logic target_wrong;

   assign target_wrong = (rs_pred_tgt != rs_act_tgt);
   assign wr_en = rs_valid && (rs_kind == KIND_INDIRECT) && target_wrong;

endmodule

// File: rtl/itp_predictor.sv
module itp_predictor #(
   parameter int IP_W      = 32,
   parameter int HIST_W    = 16,
   parameter int IP_LSB    = 0,
   parameter int IDX_W     = 8,
   parameter int TAG_W     = 8,
   parameter int TGT_W     = 32,
   parameter bit FOLD_HIST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IP_W-1:0]   fe_ip,
   input  logic [HIST_W-1:0] fe_ghr,
   input  logic              fb_hit,
   input  logic [1:0]        fb_kind,
   input  logic [TGT_W-1:0]  fb_tgt,
   output logic [TGT_W-1:0]  pred_tgt,
   input  logic              rs_valid,
   input  logic [IP_W-1:0]   rs_ip,
   input  logic [HIST_W-1:0] rs_ghr,
   input  logic [1:0]        rs_kind,
   input  logic [TGT_W-1:0]  rs_pred_tgt,
   input  logic [TGT_W-1:0]  rs_act_tgt
);
   localparam int DEPTH = 1 << IDX_W;

   logic [IDX_W-1:0] f_idx, r_idx;
   logic [TAG_W-1:0] f_tag, r_tag;
   logic             tbl_hit;
   logic [TGT_W-1:0] tbl_tgt;
   logic             wr_en;
   logic [DEPTH-1:0] vld_vec;

   itp_hash #(
      .IP_W(IP_W), .HIST_W(HIST_W), .IP_LSB(IP_LSB),
      .IDX_W(IDX_W), .TAG_W(TAG_W), .FOLD_HIST(FOLD_HIST)
   ) u_fhash (
      .ip(fe_ip), .hist(fe_ghr), .idx(f_idx), .tag(f_tag)
   );

   itp_hash #(
      .IP_W(IP_W), .HIST_W(HIST_W), .IP_LSB(IP_LSB),
      .IDX_W(IDX_W), .TAG_W(TAG_W), .FOLD_HIST(FOLD_HIST)
   ) u_rhash (
      .ip(rs_ip), .hist(rs_ghr), .idx(r_idx), .tag(r_tag)
   );

   itp_update #(.TGT_W(TGT_W)) u_upd (
      .rs_valid(rs_valid), .rs_kind(rs_kind),
      .rs_pred_tgt(rs_pred_tgt), .rs_act_tgt(rs_act_tgt),
      .wr_en(wr_en)
   );

   itp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(f_idx), .rd_tag(f_tag), .rd_hit(tbl_hit), .rd_tgt(tbl_tgt),
      .wr_en(wr_en), .wr_idx(r_idx), .wr_tag(r_tag), .wr_tgt(rs_act_tgt),
      .vld_o(vld_vec)
   );

   itp_select #(.TGT_W(TGT_W)) u_sel (
      .base_hit(fb_hit), .base_kind(fb_kind), .base_tgt(fb_tgt),
      .tbl_hit(tbl_hit), .tbl_tgt(tbl_tgt), .out_tgt(pred_tgt)
   );

endmodule

// File: rtl/itp_predictor_chk.sv
module itp_predictor_chk
   import itp_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int TGT_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  fb_hit,
   input logic [1:0]            fb_kind,
   input logic [TGT_W-1:0]      fb_tgt,
   input logic [TGT_W-1:0]      pred_tgt,
   input logic                  rs_valid,
   input logic [1:0]            rs_kind,
   input logic [TGT_W-1:0]      rs_pred_tgt,
   input logic [TGT_W-1:0]      rs_act_tgt,
   input logic [IDX_W-1:0]      r_idx,
   input logic [(1<<IDX_W)-1:0] vld_vec
);
   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |-> (vld_vec == '0));

   // R3
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fb_hit || fb_kind != KIND_INDIRECT) |-> (pred_tgt == fb_tgt));

   // R5
   alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && rs_kind == KIND_INDIRECT && rs_pred_tgt != rs_act_tgt)
      |=> vld_vec[$past(r_idx)]);

   // R6
   correct_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && rs_pred_tgt == rs_act_tgt) |=> $stable(vld_vec));

   // R7
   kind_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && rs_kind != KIND_INDIRECT) |=> $stable(vld_vec));

endmodule

bind itp_predictor itp_predictor_chk #(.IDX_W(IDX_W), .TGT_W(TGT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fb_hit(fb_hit), .fb_kind(fb_kind),
   .fb_tgt(fb_tgt), .pred_tgt(pred_tgt), .rs_valid(rs_valid),
   .rs_kind(rs_kind), .rs_pred_tgt(rs_pred_tgt), .rs_act_tgt(rs_act_tgt),
   .r_idx(r_idx), .vld_vec(vld_vec)
);

// File: tb/itp_predictor_tb.sv
module itp_predictor_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'hBA5E_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] fe_ip;
   logic [15:0] fe_ghr;
   logic        fb_hit;
   logic [1:0]  fb_kind;
   logic [31:0] fb_tgt;
   logic [31:0] pred_tgt;
   logic        rs_valid;
   logic [31:0] rs_ip;
   logic [15:0] rs_ghr;
   logic [1:0]  rs_kind;
   logic [31:0] rs_pred_tgt;
   logic [31:0] rs_act_tgt;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   itp_predictor u_dut (
      .clk(clk), .rst_n(rst_n), .fe_ip(fe_ip), .fe_ghr(fe_ghr),
      .fb_hit(fb_hit), .fb_kind(fb_kind), .fb_tgt(fb_tgt), .pred_tgt(pred_tgt),
      .rs_valid(rs_valid), .rs_ip(rs_ip), .rs_ghr(rs_ghr), .rs_kind(rs_kind),
      .rs_pred_tgt(rs_pred_tgt), .rs_act_tgt(rs_act_tgt)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: pred_tgt=%h expected=%h", req, act, exp);
      end
   endtask

   // drive a fetch at the current negedge and sample after settling
   task automatic look(input string req, input logic [31:0] ip, input logic [15:0] ghr,
                       input logic hit, input logic [1:0] kind, input logic [31:0] exp);
      fe_ip = ip; fe_ghr = ghr; fb_hit = hit; fb_kind = kind; fb_tgt = BASE;
      #1;
      check(req, pred_tgt, exp);
   endtask

   // one-cycle resolve record, written at the following posedge
   task automatic resolve(input logic [31:0] ip, input logic [15:0] ghr, input logic [1:0] kind,
                          input logic [31:0] pt, input logic [31:0] at);
      @(negedge clk);
      rs_valid = 1'b1; rs_ip = ip; rs_ghr = ghr; rs_kind = kind;
      rs_pred_tgt = pt; rs_act_tgt = at;
      @(negedge clk);
      rs_valid = 1'b0;
   endtask

   task automatic t_reset();
      look("R1", 32'h0000_1234, 16'h00F0, 1'b1, 2'b11, BASE);
      look("R1", 32'h0000_0000, 16'h0000, 1'b1, 2'b11, BASE);
   endtask

   task automatic t_alloc_same_cycle();
      // R12: write and lookup of the same key in one cycle
      @(negedge clk);
      rs_valid = 1'b1; rs_ip = 32'h0000_1234; rs_ghr = 16'h00F0; rs_kind = 2'b11;
      rs_pred_tgt = BASE; rs_act_tgt = 32'hAAAA_0001;
      look("R12 old contents", 32'h0000_1234, 16'h00F0, 1'b1, 2'b11, BASE);
      @(negedge clk);
      rs_valid = 1'b0;
      look("R12 next cycle", 32'h0000_1234, 16'h00F0, 1'b1, 2'b11, 32'hAAAA_0001);
      look("R5 R2 allocate", 32'h0000_1234, 16'h00F0, 1'b1, 2'b11, 32'hAAAA_0001);
   endtask

   task automatic t_gating();
      look("R3 base miss", 32'h0000_1234, 16'h00F0, 1'b0, 2'b11, BASE);
      look("R3 conditional", 32'h0000_1234, 16'h00F0, 1'b1, 2'b00, BASE);
      look("R3 return", 32'h0000_1234, 16'h00F0, 1'b1, 2'b01, BASE);
      look("R3 call", 32'h0000_1234, 16'h00F0, 1'b1, 2'b10, BASE);
   endtask

   task automatic t_key();
      look("R4 upper ip bits", 32'hABCD_1234, 16'h00F0, 1'b1, 2'b11, 32'hAAAA_0001);
      look("R4 xor alias", 32'h0000_1234 ^ 32'h0000_0505, 16'h00F0 ^ 16'h0505,
           1'b1, 2'b11, 32'hAAAA_0001);
   endtask

   task automatic t_contexts();
      look("R8 second ctx miss", 32'h0000_1234, 16'h0F00, 1'b1, 2'b11, BASE);
      resolve(32'h0000_1234, 16'h0F00, 2'b11, BASE, 32'hBBBB_0002);
      look("R8 second ctx", 32'h0000_1234, 16'h0F00, 1'b1, 2'b11, 32'hBBBB_0002);
      look("R8 first ctx kept", 32'h0000_1234, 16'h00F0, 1'b1, 2'b11, 32'hAAAA_0001);
   endtask

   task automatic t_nowrite();
      resolve(32'h0000_4000, 16'h0011, 2'b11, 32'hCCCC_0003, 32'hCCCC_0003);
      look("R6 correct target", 32'h0000_4000, 16'h0011, 1'b1, 2'b11, BASE);
      resolve(32'h0000_5000, 16'h0022, 2'b00, BASE, 32'hDDDD_0004);
      look("R7 conditional kind", 32'h0000_5000, 16'h0022, 1'b1, 2'b11, BASE);
      resolve(32'h0000_5000, 16'h0022, 2'b10, BASE, 32'hDDDD_0004);
      look("R7 call kind", 32'h0000_5000, 16'h0022, 1'b1, 2'b11, BASE);
   endtask

   task automatic t_tag_replace();
      // key 0x13C4: same index C4 as key 0x12C4, tag 13 instead of 12
      look("R9 tag mismatch", 32'h0000_1234, 16'h01F0, 1'b1, 2'b11, BASE);
      resolve(32'h0000_1234, 16'h01F0, 2'b11, BASE, 32'hEEEE_0005);
      look("R10 new owner", 32'h0000_1234, 16'h01F0, 1'b1, 2'b11, 32'hEEEE_0005);
      look("R10 old key evicted", 32'h0000_1234, 16'h00F0, 1'b1, 2'b11, BASE);
   endtask

   task automatic t_overwrite();
      resolve(32'h0000_1234, 16'h0F00, 2'b11, 32'hBBBB_0002, 32'hFFFF_0006);
      look("R11 overwrite", 32'h0000_1234, 16'h0F00, 1'b1, 2'b11, 32'hFFFF_0006);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD*2000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0;
      fe_ip = '0; fe_ghr = '0; fb_hit = 1'b0; fb_kind = 2'b00; fb_tgt = BASE;
      rs_valid = 1'b0; rs_ip = '0; rs_ghr = '0; rs_kind = 2'b00;
      rs_pred_tgt = '0; rs_act_tgt = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alloc_same_cycle();
      t_gating();
      t_key();
      t_contexts();
      t_nowrite();
      t_tag_replace();
      t_overwrite();
      done = 1'b1;
      finish_run();
   end

endmodule